// File: doc/BRIEF.md
# SPI FIFO status and interrupt unit

This unit sits between a serial shift engine and a software register interface. It holds a transmit FIFO and a receive FIFO, each 8 words of 32 bits by default, and produces the flags software and the shift engine need to pace a transfer: empty, full and a "half" flag that compares the fill level against a programmable watermark. Pushing into a full FIFO or popping from an empty one counts as a transfer error.

Eight status conditions (busy, error, and the three flags of each FIFO) feed eight sticky interrupt bits. A bit is set when its condition rises, stays set until software writes 1 to it through the clear register, and drives the single interrupt output only when its enable bit is set. The shift engine uses the transmit pop port and the receive push port; software uses the transmit push port, the receive pop port and the register port. Register reads are combinational on the address; writes take effect on the clock edge.

Top module: `spi_fifo_irq`

## Requirements
- R1: Register address 0 returns the status word: bit 0 = `xfer_busy`, bit 1 = transfer error, bits 2/3/4 = TX empty/half/full, bits 5/6/7 = RX empty/half/full.
- R2: Each FIFO returns words in push order on its pop data port (valid while non-empty); addresses 6 and 7 return the TX and RX fill levels.
- R3: A half flag is 1 exactly when that FIFO's level is greater than or equal to its watermark; the TX and RX watermarks are read and written at addresses 4 and 5 (low 4 bits) and reset to 4.
- R4: A FIFO reports full at 8 entries; a push into a full FIFO is dropped (overflow) and a pop from an empty FIFO changes nothing (underflow).
- R5: The error bit of the status word is 1 for exactly the one cycle after any cycle with an overflow or underflow on either FIFO.
- R6: Interrupt status (address 2) bit i becomes 1 on the clock edge after status-word bit i goes from 0 to 1, and then stays 1.
- R7: Writing address 3 clears each interrupt status bit whose write-data bit is 1; bits written 0 are unchanged; a bit whose event arrives in the same cycle as its clear stays 1; address 3 reads as 0.
- R8: Address 1 holds the interrupt enables (reset 0); `irq` is 1 exactly when some interrupt status bit and its enable are both 1.
- R9: After reset both levels are 0, the status word is 0x24 (plus `xfer_busy`), interrupt status is 0, and no edge is seen on the two empty flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_busy | input | 1 | Transfer-in-progress indication from the shift engine |
| tx_push | input | 1 | Write one word into the TX FIFO |
| tx_push_data | input | 32 | Word to write into the TX FIFO |
| tx_pop | input | 1 | Remove the head word of the TX FIFO |
| tx_pop_data | output | 32 | Head word of the TX FIFO |
| rx_push | input | 1 | Write one word into the RX FIFO |
| rx_push_data | input | 32 | Word to write into the RX FIFO |
| rx_pop | input | 1 | Remove the head word of the RX FIFO |
| rx_pop_data | output | 32 | Head word of the RX FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions watch, on every cycle, that levels never pass the depth, that a push into a full FIFO leaves it full and a pop from an empty one leaves it empty, that an overflow or underflow raises the error bit on the next cycle, that a rising condition lands in the interrupt status and that a clear only removes bits with no new event. Data ordering, the exact watermark comparison after reprogramming, the zero effect of clear bits written 0 and the enable masking on `irq` are shown only by the bench, which runs directed fill/drain, watermark and clear scenarios and then long random traffic against a queue-based model compared every clock.

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq #(
  parameter int DW     = 32,
  parameter int DEPTH  = 8,
  parameter int WM_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_busy,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_push_data,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pop_data,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_push_data,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [7:0] COND_RST = 8'h24;

  // index 0 = transmit, index 1 = receive
  logic [1:0]    push, pop, f_empty, f_half, f_full, ovf, unf;
  logic [DW-1:0] pdata [2];
  logic [DW-1:0] qdata [2];
  logic [LW-1:0] lvl   [2];
  logic [LW-1:0] wm    [2];

  assign push     = {rx_push, tx_push};
  assign pop      = {rx_pop, tx_pop};
  assign pdata[0] = tx_push_data;
  assign pdata[1] = rx_push_data;
  assign tx_pop_data = qdata[0];
  assign rx_pop_data = qdata[1];

  for (genvar g = 0; g < 2; g++) begin : g_fifo
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign do_push = push[g] & ~f_full[g];
    assign do_pop  = pop[g] & ~f_empty[g];

    always_ff @(posedge clk)
      if (do_push) mem[wp] <= pdata[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + LW'(do_push) - LW'(do_pop);
      end
    end

    assign lvl[g]     = cnt;
    assign qdata[g]   = mem[rp];
    assign f_empty[g] = (cnt == '0);
    assign f_full[g]  = (cnt == LW'(DEPTH));
    assign f_half[g]  = (cnt >= wm[g]);
    assign ovf[g]     = push[g] & f_full[g];
    assign unf[g]     = pop[g] & f_empty[g];

    // R4: level never exceeds the depth
    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LW'(DEPTH));
    // R4: a push into a full FIFO is dropped
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push[g] && f_full[g] && !pop[g]) |=> f_full[g]);
    // R4: a pop from an empty FIFO changes nothing
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (pop[g] && f_empty[g] && !push[g]) |=> f_empty[g]);
  end

  logic       err_q;
  logic [7:0] cond, prev, irq_st, irq_en, rise, clr;
  logic       wr_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |(ovf | unf);
  end

  assign cond = {f_full[1], f_half[1], f_empty[1],
                 f_full[0], f_half[0], f_empty[0], err_q, xfer_busy};
  assign rise   = cond & ~prev;
  assign wr_clr = reg_wr && (reg_addr == 3'd3);
  assign clr    = wr_clr ? reg_wdata : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= COND_RST;
      irq_st <= '0;
      irq_en <= '0;
      wm[0]  <= LW'(WM_RST);
      wm[1]  <= LW'(WM_RST);
    end else begin
      prev   <= cond;
      irq_st <= (irq_st & ~clr) | rise;
      if (reg_wr && reg_addr == 3'd1) irq_en <= reg_wdata;
      if (reg_wr && reg_addr == 3'd4) wm[0] <= reg_wdata[LW-1:0];
      if (reg_wr && reg_addr == 3'd5) wm[1] <= reg_wdata[LW-1:0];
    end
  end

  assign irq = |(irq_st & irq_en);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = cond;
      3'd1:    reg_rdata = irq_en;
      3'd2:    reg_rdata = irq_st;
      3'd4:    reg_rdata = 8'(wm[0]);
      3'd5:    reg_rdata = 8'(wm[1]);
      3'd6:    reg_rdata = 8'(lvl[0]);
      3'd7:    reg_rdata = 8'(lvl[1]);
      default: reg_rdata = 8'h00;
    endcase
  end

  // R5: any overflow or underflow shows as the error bit next cycle
  a_r5_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf | unf)) |=> cond[1]);
  // R5: the error bit never appears without a preceding fault
  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ovf | unf)) |=> !cond[1]);
  // R6: a rising condition is recorded in the interrupt status
  a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != 8'h00) |=> ((irq_st & $past(rise)) == $past(rise)));
  // R7: a clear with no new event removes every bit written 1
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && rise == 8'h00) |=> ((irq_st & $past(reg_wdata)) == 8'h00));
  // R8: the interrupt output needs at least one enable
  a_r8_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en != 8'h00));
endmodule

// File: tb/sim_spi_fifo_irq.sv
module sim_spi_fifo_irq;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_busy = 1'b0;
  logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [31:0] tx_push_data = '0, rx_push_data = '0;
  logic [31:0] tx_pop_data, rx_pop_data;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;

  always #4 clk = ~clk;

  spi_fifo_irq u0 (.clk, .rst_n, .xfer_busy, .tx_push, .tx_push_data, .tx_pop,
    .tx_pop_data, .rx_push, .rx_push_data, .rx_pop, .rx_pop_data, .reg_wr,
    .reg_addr, .reg_wdata, .reg_rdata, .irq);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference model
  logic [31:0] txq[$], rxq[$];
  int  m_wm0, m_wm1;
  logic [7:0] m_en, m_st, m_prev;
  bit  m_err;

  function automatic logic [7:0] m_cond();
    logic [7:0] c;
    c[0] = xfer_busy;
    c[1] = m_err;
    c[2] = (txq.size() == 0);
    c[3] = (txq.size() >= m_wm0);
    c[4] = (txq.size() == D);
    c[5] = (rxq.size() == 0);
    c[6] = (rxq.size() >= m_wm1);
    c[7] = (rxq.size() == D);
    return c;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cond();
      3'd1: return m_en;
      3'd2: return m_st;
      3'd4: return 8'(m_wm0);
      3'd5: return 8'(m_wm1);
      3'd6: return 8'(txq.size());
      3'd7: return 8'(rxq.size());
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R8";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4, 3'd5: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    txq.delete(); rxq.delete();
    m_wm0 = 4; m_wm1 = 4; m_en = 0; m_st = 0; m_prev = 8'h24; m_err = 0;
  endtask

  task automatic compare();
    chk(tag(reg_addr), "reg read", 32'(reg_rdata), 32'(m_read(reg_addr)));
    chk("R8", "irq", 32'(irq), 32'(|(m_st & m_en)));
    if (txq.size() > 0) chk("R2", "tx head", tx_pop_data, txq[0]);
    if (rxq.size() > 0) chk("R2", "rx head", rx_pop_data, rxq[0]);
  endtask

  task automatic m_update();
    logic [7:0] c, clr;
    bit tf, te, rf, re, fault;
    c = m_cond();
    tf = txq.size() == D; te = txq.size() == 0;
    rf = rxq.size() == D; re = rxq.size() == 0;
    fault = (tx_push && tf) || (tx_pop && te) || (rx_push && rf) || (rx_pop && re);
    if (tx_pop && !te) void'(txq.pop_front());
    if (tx_push && !tf) txq.push_back(tx_push_data);
    if (rx_pop && !re) void'(rxq.pop_front());
    if (rx_push && !rf) rxq.push_back(rx_push_data);
    clr = (reg_wr && reg_addr == 3'd3) ? reg_wdata : 8'h00;
    m_st = (m_st & ~clr) | (c & ~m_prev);
    m_prev = c;
    m_err = fault;
    if (reg_wr && reg_addr == 3'd1) m_en = reg_wdata;
    if (reg_wr && reg_addr == 3'd4) m_wm0 = int'(reg_wdata[3:0]);
    if (reg_wr && reg_addr == 3'd5) m_wm1 = int'(reg_wdata[3:0]);
  endtask

  // one clock: inputs were set at the negedge, compare, advance model, wait
  task automatic step(input bit tp, input bit tpp, input bit rp, input bit rpp,
                      input bit busy, input bit wr, input logic [2:0] a,
                      input logic [7:0] wd);
    tx_push = tp; tx_pop = tpp; rx_push = rp; rx_pop = rpp;
    tx_push_data = $urandom; rx_push_data = $urandom;
    xfer_busy = busy; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    compare();
    m_update();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state at the ports
    reg_addr = 3'd0; #1; chk("R9", "status after reset", 32'(reg_rdata), 32'h24);
    reg_addr = 3'd2; #1; chk("R9", "irq status after reset", 32'(reg_rdata), 32'h00);
    reg_addr = 3'd4; #1; chk("R9", "tx watermark after reset", 32'(reg_rdata), 32'h04);
    reg_addr = 3'd7; #1; chk("R9", "rx level after reset", 32'(reg_rdata), 32'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: no edge on the empty flags right after reset
    step(0,0,0,0,0,0,3'd2,8'h00);
    step(0,0,0,0,0,0,3'd2,8'h00);
    // R8: enable all interrupts
    step(0,0,0,0,0,1,3'd1,8'hFF);
    // R4/R3: fill TX past full, reading status and level alternately
    for (int i = 0; i < 11; i++) step(1,0,0,0,1,0,(i % 2) ? 3'd6 : 3'd0,8'h00);
    // R5: error pulse visible the cycle after
    step(0,0,0,0,0,0,3'd0,8'h00);
    step(0,0,0,0,0,0,3'd2,8'h00);
    // R2/R4: drain TX in order, then underflow
    for (int i = 0; i < 10; i++) step(0,1,0,0,0,0,3'd6,8'h00);
    step(0,0,0,0,0,0,3'd0,8'h00);
    // R7: writing 0 clears nothing, then clear all
    step(0,0,0,0,0,1,3'd3,8'h00);
    step(0,0,0,0,0,0,3'd2,8'h00);
    step(0,0,0,0,0,1,3'd3,8'hFF);
    step(0,0,0,0,0,0,3'd2,8'h00);
    // R7: clear in the same cycle as a new busy edge: event wins
    step(0,0,0,0,0,0,3'd2,8'h00);
    step(0,0,0,0,1,1,3'd3,8'h01);
    step(0,0,0,0,1,0,3'd2,8'h00);
    // R3: watermark 0, 8 and 2 on RX while filling and draining both ways
    step(0,0,0,0,0,1,3'd5,8'h00);
    step(0,0,0,0,0,0,3'd0,8'h00);
    step(0,0,0,0,0,1,3'd5,8'h08);
    for (int i = 0; i < 9; i++) step(0,0,1,0,0,0,(i % 2) ? 3'd7 : 3'd0,8'h00);
    step(0,0,0,0,0,1,3'd5,8'h02);
    for (int i = 0; i < 9; i++) step(0,0,1,1,0,0,3'd0,8'h00);
    for (int i = 0; i < 10; i++) step(0,0,0,1,0,0,(i % 2) ? 3'd7 : 3'd0,8'h00);
    // R8: mask interrupts, the sticky bits stay but irq drops
    step(0,0,0,0,0,1,3'd1,8'h00);
    step(0,0,0,0,0,0,3'd1,8'h00);
    // R1..R8: random traffic with register writes
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [2:0] a;
      bit w;
      r = int'($urandom_range(0, 99));
      a = 3'($urandom_range(0, 7));
      w = (r < 12) && (a inside {3'd1, 3'd3, 3'd4, 3'd5});
      step($urandom_range(0,2) != 0, $urandom_range(0,2) == 0,
           $urandom_range(0,2) == 0, $urandom_range(0,2) != 0,
           $urandom_range(0,3) == 0, w, a, 8'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule